// File: doc/BRIEF.md
# Dual-Select Reservation Station

This block is a six-entry scheduling window that sits between the dispatch stage of a core and a two-pipe integer unit. Each cycle it can take one new instruction into any free entry. For each of the two sources it stores either a finished value or the tag of the instruction that will produce it. A shared result broadcast port, carrying a tag, a value and a valid bit, is compared against every waiting source. A matching source takes the value and is then marked as held.

Once both sources of an entry hold values, the entry is eligible to issue. Each cycle the station picks up to two eligible entries from the whole pool and drives them onto two issue ports. The oldest eligible entry goes to port 0 and the next oldest to port 1. A younger entry therefore overtakes an older one that is still waiting. Age is kept as a compact per-entry dispatch sequence number. When the pool is full, dispatch is held off through the ready/valid handshake. A flush input empties the whole pool in one cycle.

Each entry is a small state machine with three states:
- Empty to Waiting: dispatch with at least one source still unresolved.
- Empty to Ready: dispatch with both sources resolved, counting a same-cycle broadcast.
- Waiting to Ready: a broadcast fills the last unresolved source.
- Ready to Empty: the entry is selected for issue.
- Any state to Empty: flush.

Top module: `dual_select_rs`

## Requirements
- R1: After reset no entry is occupied. `disp_ready` is 1 and both issue valids are 0.
- R2: A dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are both 1, at most one per cycle. Six entries are the capacity. With six occupied, `disp_ready` is 0 and `disp_valid` adds nothing.
- R3: An entry dispatched with both sources marked as values is presented for issue in the cycle after the dispatch edge.
- R4: A waiting source whose tag equals `bc_tag` while `bc_valid` is 1 takes `bc_data`. If this completes the entry, it is presented for issue in the cycle after that edge.
- R5: A broadcast in the same cycle as a dispatch is captured by the new entry for every unresolved source whose tag matches.
- R6: At most two entries issue per cycle. Port 0 carries the oldest eligible entry and port 1 the next oldest. `iss1_valid` is never 1 while `iss0_valid` is 0.
- R7: A younger eligible entry issues while an older entry is still waiting for an operand.
- R8: An entry leaves the pool in the cycle it issues. If the pool was full, `disp_ready` returns to 1 in the following cycle.
- R9: While `flush` is 1, both issue valids and `disp_ready` are 0, and a dispatch offered in that cycle is dropped. From the next cycle the pool is empty, and a later broadcast brings none of the flushed entries back.
- R10: A broadcast whose tag matches no waiting source leaves every entry unchanged, and no entry issues because of it.
- R11: Each issue port carries the opcode and the two resolved source values of the entry it presents. A source dispatched as a value keeps that value, and a source resolved by broadcast carries the broadcast data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty every entry this cycle |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free entry exists and no flush is active |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_a_have | input | 1 | Source A is a value (1) or a producer tag (0) |
| disp_a_val | input | DATA_W | Source A value |
| disp_a_tag | input | TAG_W | Source A producer tag |
| disp_b_have | input | 1 | Source B is a value (1) or a producer tag (0) |
| disp_b_val | input | DATA_W | Source B value |
| disp_b_tag | input | TAG_W | Source B producer tag |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| iss0_valid | output | 1 | Issue port 0 carries the oldest eligible entry |
| iss0_op | output | OP_W | Port 0 opcode |
| iss0_a | output | DATA_W | Port 0 source A |
| iss0_b | output | DATA_W | Port 0 source B |
| iss1_valid | output | 1 | Issue port 1 carries the next-oldest eligible entry |
| iss1_op | output | OP_W | Port 1 opcode |
| iss1_a | output | DATA_W | Port 1 source A |
| iss1_b | output | DATA_W | Port 1 source B |

## Verification
The bench goes after ordering first. It makes four entries eligible on the same broadcast and checks that they drain two per cycle, oldest first. A design that mishandled age after entries leave would swap the ports or repeat an entry. It also checks that a broadcast landing with a dispatch is caught, since a design without that bypass leaves the entry waiting forever. It fills the pool and checks that `disp_ready` only recovers the cycle after an issue; an off-by-one there either overwrites a live entry or stalls one cycle too long. Flush is probed with a dispatch and a broadcast in the same cycle, where a leaky design would issue a ghost entry. A long randomized run then compares every port on every clock against a queue model.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_st_e;

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int OP_W   = 8,
    parameter int RK_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_op,
    input  logic              wr_a_have,
    input  logic [DATA_W-1:0] wr_a_val,
    input  logic [TAG_W-1:0]  wr_a_tag,
    input  logic              wr_b_have,
    input  logic [DATA_W-1:0] wr_b_val,
    input  logic [TAG_W-1:0]  wr_b_tag,
    input  logic [RK_W-1:0]   wr_rank,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              issue,
    input  logic [1:0]        rank_drop,
    output slot_st_e          st,
    output logic [RK_W-1:0]   rank,
    output logic [OP_W-1:0]   op_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q
);

    localparam int PAY_W = (DATA_W > TAG_W) ? DATA_W : TAG_W;

    slot_st_e          st_q, st_n;
    logic [RK_W-1:0]   rank_q, rank_n;
    logic [OP_W-1:0]   op_n;
    logic              a_have_q, a_have_n, b_have_q, b_have_n;
    logic [PAY_W-1:0]  a_pay_q, a_pay_n, b_pay_q, b_pay_n;

    // new-entry source capture, including same-cycle broadcast bypass
    logic              wa_have, wb_have, ha_have, hb_have;
    logic [PAY_W-1:0]  wa_pay, wb_pay, ha_pay, hb_pay;

    always_comb begin
        if (wr_a_have) begin
            wa_have = 1'b1;
            wa_pay  = PAY_W'(wr_a_val);
        end else if (bc_valid && bc_tag == wr_a_tag) begin
            wa_have = 1'b1;
            wa_pay  = PAY_W'(bc_data);
        end else begin
            wa_have = 1'b0;
            wa_pay  = PAY_W'(wr_a_tag);
        end
        if (wr_b_have) begin
            wb_have = 1'b1;
            wb_pay  = PAY_W'(wr_b_val);
        end else if (bc_valid && bc_tag == wr_b_tag) begin
            wb_have = 1'b1;
            wb_pay  = PAY_W'(bc_data);
        end else begin
            wb_have = 1'b0;
            wb_pay  = PAY_W'(wr_b_tag);
        end
        // snoop for held sources
        if (!a_have_q && bc_valid && a_pay_q[TAG_W-1:0] == bc_tag) begin
            ha_have = 1'b1;
            ha_pay  = PAY_W'(bc_data);
        end else begin
            ha_have = a_have_q;
            ha_pay  = a_pay_q;
        end
        if (!b_have_q && bc_valid && b_pay_q[TAG_W-1:0] == bc_tag) begin
            hb_have = 1'b1;
            hb_pay  = PAY_W'(bc_data);
        end else begin
            hb_have = b_have_q;
            hb_pay  = b_pay_q;
        end
    end

    // next-state and field update
    always_comb begin
        st_n     = st_q;
        rank_n   = rank_q - RK_W'(rank_drop);
        op_n     = op_q;
        a_have_n = ha_have;
        a_pay_n  = ha_pay;
        b_have_n = hb_have;
        b_pay_n  = hb_pay;
        unique case (st_q)
            SLOT_EMPTY: begin
                if (wr_en) begin
                    st_n     = (wa_have && wb_have) ? SLOT_READY : SLOT_WAIT;
                    rank_n   = wr_rank;
                    op_n     = wr_op;
                    a_have_n = wa_have;
                    a_pay_n  = wa_pay;
                    b_have_n = wb_have;
                    b_pay_n  = wb_pay;
                end
            end
            SLOT_WAIT: begin
                if (ha_have && hb_have) st_n = SLOT_READY;
            end
            SLOT_READY: begin
                if (issue) st_n = SLOT_EMPTY;
            end
            default: st_n = SLOT_EMPTY;
        endcase
        if (flush) st_n = SLOT_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_n;
    end

    // entry fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rank_q   <= '0;
            op_q     <= '0;
            a_have_q <= 1'b0;
            b_have_q <= 1'b0;
            a_pay_q  <= '0;
            b_pay_q  <= '0;
        end else begin
            rank_q   <= rank_n;
            op_q     <= op_n;
            a_have_q <= a_have_n;
            b_have_q <= b_have_n;
            a_pay_q  <= a_pay_n;
            b_pay_q  <= b_pay_n;
        end
    end

    assign st   = st_q;
    assign rank = rank_q;
    assign a_q  = a_pay_q[DATA_W-1:0];
    assign b_q  = b_pay_q[DATA_W-1:0];

    AST_WRITE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> st_q == SLOT_EMPTY); // R2
    AST_ISSUE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> st_q == SLOT_READY); // R6
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_READY && !issue && !flush) |=> st_q == SLOT_READY); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q == SLOT_EMPTY); // R9

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int NENT  = 6,
    parameter int RK_W  = 3,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NENT-1:0]            rdy,
    input  logic [NENT-1:0][RK_W-1:0]  ranks,
    output logic                       g0,
    output logic [IDX_W-1:0]           idx0,
    output logic                       g1,
    output logic [IDX_W-1:0]           idx1
);

    logic [RK_W:0] older_cnt [NENT];

    // per entry: how many eligible entries are older
    always_comb begin
        for (int i = 0; i < NENT; i++) begin
            older_cnt[i] = '0;
            for (int j = 0; j < NENT; j++) begin
                if (j != i && rdy[j] && ranks[j] < ranks[i])
                    older_cnt[i] = older_cnt[i] + (RK_W+1)'(1);
            end
        end
    end

    always_comb begin
        g0   = 1'b0;
        g1   = 1'b0;
        idx0 = '0;
        idx1 = '0;
        for (int i = 0; i < NENT; i++) begin
            if (rdy[i] && older_cnt[i] == '0) begin
                g0   = 1'b1;
                idx0 = IDX_W'(i);
            end
            if (rdy[i] && older_cnt[i] == (RK_W+1)'(1)) begin
                g1   = 1'b1;
                idx1 = IDX_W'(i);
            end
        end
    end

    AST_PICK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (g0 && g1) |-> idx0 != idx1); // R6
    AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (g0 && g1) |-> ranks[idx0] < ranks[idx1]); // R6
    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        g1 |-> g0); // R6

endmodule

// File: rtl/dual_select_rs.sv
module dual_select_rs
    import rs_pkg::*;
#(
    parameter int NENT   = 6,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 6,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [OP_W-1:0]   disp_op,
    input  logic              disp_a_have,
    input  logic [DATA_W-1:0] disp_a_val,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic              disp_b_have,
    input  logic [DATA_W-1:0] disp_b_val,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              iss0_valid,
    output logic [OP_W-1:0]   iss0_op,
    output logic [DATA_W-1:0] iss0_a,
    output logic [DATA_W-1:0] iss0_b,
    output logic              iss1_valid,
    output logic [OP_W-1:0]   iss1_op,
    output logic [DATA_W-1:0] iss1_a,
    output logic [DATA_W-1:0] iss1_b
);

    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int RK_W  = IDX_W;
    localparam int CNT_W = $clog2(NENT + 1);

    slot_st_e                  st [NENT];
    logic [NENT-1:0][RK_W-1:0] ranks;
    logic [OP_W-1:0]           ops  [NENT];
    logic [DATA_W-1:0]         avs  [NENT];
    logic [DATA_W-1:0]         bvs  [NENT];
    logic [NENT-1:0]           rdy, wr_sel, iss_sel;
    logic [1:0]                drop [NENT];
    logic                      g0, g1, disp_fire;
    logic [IDX_W-1:0]          idx0, idx1, free_idx;
    logic [CNT_W-1:0]          occ;
    logic [RK_W-1:0]           new_rank;

    // occupancy, free slot and eligibility
    always_comb begin
        occ      = '0;
        free_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (st[i] == SLOT_EMPTY) free_idx = IDX_W'(i);
            else                     occ = occ + CNT_W'(1);
            rdy[i] = (st[i] == SLOT_READY) && !flush;
        end
    end

    assign disp_ready = !flush && (occ != CNT_W'(NENT));
    assign disp_fire  = disp_valid && disp_ready;
    assign new_rank   = RK_W'(occ - CNT_W'(g0) - CNT_W'(g1));

    rs_pick #(.NENT(NENT), .RK_W(RK_W), .IDX_W(IDX_W)) i_pick (
        .clk(clk), .rst_n(rst_n), .rdy(rdy), .ranks(ranks),
        .g0(g0), .idx0(idx0), .g1(g1), .idx1(idx1)
    );

    for (genvar gi = 0; gi < NENT; gi++) begin : g_slot
        assign wr_sel[gi]  = disp_fire && (free_idx == IDX_W'(gi));
        assign iss_sel[gi] = (g0 && idx0 == IDX_W'(gi)) || (g1 && idx1 == IDX_W'(gi));
        assign drop[gi]    = {1'b0, (g0 && ranks[idx0] < ranks[gi])}
                           + {1'b0, (g1 && ranks[idx1] < ranks[gi])};

        rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .RK_W(RK_W)) i_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .wr_en(wr_sel[gi]), .wr_op(disp_op),
            .wr_a_have(disp_a_have), .wr_a_val(disp_a_val), .wr_a_tag(disp_a_tag),
            .wr_b_have(disp_b_have), .wr_b_val(disp_b_val), .wr_b_tag(disp_b_tag),
            .wr_rank(new_rank),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .issue(iss_sel[gi]), .rank_drop(drop[gi]),
            .st(st[gi]), .rank(ranks[gi]),
            .op_q(ops[gi]), .a_q(avs[gi]), .b_q(bvs[gi])
        );
    end

    // issue ports
    always_comb begin
        iss0_valid = g0;
        iss0_op    = ops[idx0];
        iss0_a     = avs[idx0];
        iss0_b     = bvs[idx0];
        iss1_valid = g1;
        iss1_op    = ops[idx1];
        iss1_a     = avs[idx1];
        iss1_b     = bvs[idx1];
    end

    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> occ == '0); // R9
    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ({1'b0, occ} <= {1'b0, $past(occ)} + 1'b1)); // R2
    AST_NO_ISSUE_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss0_valid && !iss1_valid); // R9

endmodule

// File: tb/test_dual_select_rs.sv
`timescale 1ns/1ps
module test_dual_select_rs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [7:0]  disp_op = '0;
    logic        disp_a_have = 1'b0, disp_b_have = 1'b0;
    logic [31:0] disp_a_val = '0, disp_b_val = '0;
    logic [5:0]  disp_a_tag = '0, disp_b_tag = '0;
    logic        bc_valid = 1'b0;
    logic [5:0]  bc_tag = '0;
    logic [31:0] bc_data = '0;
    logic        iss0_valid, iss1_valid;
    logic [7:0]  iss0_op, iss1_op;
    logic [31:0] iss0_a, iss0_b, iss1_a, iss1_b;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dual_select_rs i_dual_select_rs (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_a_have(disp_a_have), .disp_a_val(disp_a_val), .disp_a_tag(disp_a_tag),
        .disp_b_have(disp_b_have), .disp_b_val(disp_b_val), .disp_b_tag(disp_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .iss0_valid(iss0_valid), .iss0_op(iss0_op), .iss0_a(iss0_a), .iss0_b(iss0_b),
        .iss1_valid(iss1_valid), .iss1_op(iss1_op), .iss1_a(iss1_a), .iss1_b(iss1_b)
    );

    // reference model: entries kept in program order
    typedef struct {
        logic [7:0]  op;
        bit          ah;
        logic [31:0] a;
        bit          bh;
        logic [31:0] b;
    } ment_t;
    ment_t mq[$];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit dv, input logic [7:0] op,
                        input bit ah, input logic [31:0] av,
                        input bit bh, input logic [31:0] bv,
                        input bit bcv, input logic [5:0] bct, input logic [31:0] bcd,
                        input bit fl);
        int  p0, p1;
        bit  exp_dr;
        disp_valid  = dv;  disp_op = op;
        disp_a_have = ah;  disp_a_val = av; disp_a_tag = av[5:0];
        disp_b_have = bh;  disp_b_val = bv; disp_b_tag = bv[5:0];
        bc_valid = bcv; bc_tag = bct; bc_data = bcd; flush = fl;
        @(negedge clk);
        p0 = -1; p1 = -1;
        if (!fl) begin
            foreach (mq[i]) begin
                if (mq[i].ah && mq[i].bh) begin
                    if (p0 < 0) p0 = i;
                    else if (p1 < 0) p1 = i;
                end
            end
        end
        exp_dr = !fl && (mq.size() < 6);
        chk("disp_ready", {31'd0, disp_ready}, {31'd0, exp_dr});
        chk("iss0_valid", {31'd0, iss0_valid}, {31'd0, p0 >= 0});
        chk("iss1_valid", {31'd0, iss1_valid}, {31'd0, p1 >= 0});
        if (p0 >= 0 && iss0_valid) begin
            chk("iss0_op", {24'd0, iss0_op}, {24'd0, mq[p0].op});
            chk("iss0_a", iss0_a, mq[p0].a);
            chk("iss0_b", iss0_b, mq[p0].b);
        end
        if (p1 >= 0 && iss1_valid) begin
            chk("iss1_op", {24'd0, iss1_op}, {24'd0, mq[p1].op});
            chk("iss1_a", iss1_a, mq[p1].a);
            chk("iss1_b", iss1_b, mq[p1].b);
        end
        @(posedge clk);
        if (fl) begin
            mq.delete();
        end else begin
            if (p1 >= 0) mq.delete(p1);
            if (p0 >= 0) mq.delete(p0);
            foreach (mq[i]) begin
                if (bcv && !mq[i].ah && mq[i].a[5:0] == bct) begin mq[i].ah = 1; mq[i].a = bcd; end
                if (bcv && !mq[i].bh && mq[i].b[5:0] == bct) begin mq[i].bh = 1; mq[i].b = bcd; end
            end
            if (dv && exp_dr) begin
                ment_t e;
                e.op = op; e.ah = ah; e.a = ah ? av : {26'd0, av[5:0]};
                e.bh = bh; e.b = bh ? bv : {26'd0, bv[5:0]};
                if (!e.ah && bcv && e.a[5:0] == bct) begin e.ah = 1; e.a = bcd; end
                if (!e.bh && bcv && e.b[5:0] == bct) begin e.bh = 1; e.b = bcd; end
                mq.push_back(e);
            end
        end
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bcast(input logic [5:0] t, input logic [31:0] d);
        step(0, 0, 0, 0, 0, 0, 1, t, d, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1"; idle(2);

        // value-only dispatch, issue next cycle with its data
        cur_req = "R3";  step(1, 8'h11, 1, 32'd100, 1, 32'd200, 0, 0, 0, 0);
        cur_req = "R11"; idle(2);

        // wakeup by broadcast, unrelated tag ignored
        cur_req = "R4";  step(1, 8'h22, 0, 32'd5, 1, 32'd7, 0, 0, 0, 0);
        cur_req = "R10"; bcast(6'd9, 32'hdead); idle(2);
        cur_req = "R4";  bcast(6'd5, 32'd55); idle(2);

        // same-cycle dispatch and broadcast
        cur_req = "R5";  step(1, 8'h33, 0, 32'd7, 1, 32'd1, 1, 6'd7, 32'd77, 0); idle(2);

        // four become eligible at once: two per cycle, oldest first
        cur_req = "R6";
        for (int k = 0; k < 4; k++) step(1, 8'h40 + 8'(k), 0, 32'd3, 1, 32'(k), 0, 0, 0, 0);
        bcast(6'd3, 32'd333); idle(3);

        // younger eligible entry passes older waiting one
        cur_req = "R7";
        step(1, 8'h50, 0, 32'd4, 1, 32'd0, 0, 0, 0, 0);
        step(1, 8'h51, 1, 32'd8, 1, 32'd9, 0, 0, 0, 0);
        idle(1); bcast(6'd4, 32'd44); idle(2);

        // fill, refuse while full, recover after issue
        cur_req = "R2";
        for (int k = 0; k < 6; k++) step(1, 8'h60 + 8'(k), 0, 32'd10, 1, 32'(k), 0, 0, 0, 0);
        step(1, 8'h66, 1, 32'd1, 1, 32'd2, 0, 0, 0, 0);
        step(1, 8'h66, 1, 32'd1, 1, 32'd2, 1, 6'd10, 32'd1010, 0);
        cur_req = "R8";
        step(1, 8'h67, 1, 32'd3, 1, 32'd4, 0, 0, 0, 0);
        step(1, 8'h68, 1, 32'd5, 1, 32'd6, 0, 0, 0, 0);
        idle(5);

        // flush with dispatch and broadcast in the same cycle
        cur_req = "R9";
        step(1, 8'h70, 0, 32'd12, 1, 32'd0, 0, 0, 0, 0);
        step(1, 8'h71, 0, 32'd12, 1, 32'd0, 0, 0, 0, 0);
        step(1, 8'h72, 1, 32'd1, 1, 32'd1, 1, 6'd12, 32'd1212, 1);
        idle(1); bcast(6'd12, 32'd1212); idle(2);

        // randomized traffic against the model
        cur_req = "R6";
        for (int k = 0; k < 600; k++) begin
            step($urandom_range(0, 9) < 7, 8'($urandom_range(0, 255)),
                 $urandom_range(0, 1) == 1, 32'($urandom_range(0, 3)) | 32'($urandom_range(0, 255) << 8),
                 $urandom_range(0, 1) == 1, 32'($urandom_range(0, 3)) | 32'($urandom_range(0, 255) << 8),
                 $urandom_range(0, 1) == 1, 6'($urandom_range(0, 3)), 32'($urandom),
                 $urandom_range(0, 99) == 0);
        end
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule